// File: doc/BRIEF.md
# Keccak Vector Logic Execute Unit

This block executes the four fused bitwise vector operations that dominate the theta, rho and chi steps of the Keccak permutation. Each cycle it can accept one 32-bit instruction word. It decodes the word and reads up to three 128-bit operands from a private 32-entry register file. It computes the result and returns it on a registered result port one cycle after issue. The result is then written back into the register file. Two of the operations act on the whole 128-bit operand as sixteen independent bytes, which for pure bitwise logic is the same as acting on all 128 bits. The other two act on two 64-bit lanes and include a rotation inside each lane.

Software or a surrounding sequencer fills the register file through a dedicated preload port and then streams instructions. A dependent instruction may issue in the cycle directly after its producer. The pending result is forwarded from the result register to the operand read, so no bubble is needed. Any word that matches none of the four encodings raises a one-cycle illegal flag, produces no result and changes no register.

Top module: `keccak_vec_xu`

## Requirements
- R1: A word with bits 31:21 = 11'h670 and bit 15 = 0 (three-way XOR) produces dest = Vn ^ Vm ^ Va over all 128 bits.
- R2: A word with bits 31:21 = 11'h671 and bit 15 = 0 (XOR with bit clear) produces dest = Vn ^ (Vm & ~Va) over all 128 bits.
- R3: A word with bits 31:21 = 11'h673 and bits 15:10 = 6'b100011 (rotate then XOR) produces, in each 64-bit lane, dest = Vn ^ (Vm rotated left by one bit).
- R4: A word with bits 31:21 = 11'h674 (XOR then rotate) produces, in each 64-bit lane, dest = (Vn ^ Vm) rotated right by the unsigned amount in bits 15:10. An amount of 0 returns the XOR unchanged, and equal n and m fields give zero.
- R5: Register fields are decoded as dest = bits 4:0, n = bits 9:5, m = bits 20:16, and a = bits 14:10 for the two three-source forms. The result port reports the dest field.
- R6: An issued word that matches none of the encodings in R1 to R4 asserts illegal for exactly one cycle, keeps res_valid low and writes no register.
- R7: A legal word issued in cycle t gives res_valid, res_dest and res_data in cycle t+1. When issue_valid is low, nothing is produced and no register changes.
- R8: An instruction issued in the cycle right after its producer reads the producer's result for any matching source field.
- R9: While rst_n is low and in the first cycle after it is released, res_valid and illegal are low.
- R10: A preload write to register r in cycle t is seen by an instruction issued in cycle t+1. A writeback to the same register in the same cycle takes priority over the preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| pre_en | input | 1 | Preload write enable |
| pre_addr | input | 5 | Preload register index |
| pre_data | input | 128 | Preload write data |
| res_valid | output | 1 | Result of the previous cycle's legal instruction |
| res_dest | output | 5 | Destination register of the result |
| res_data | output | 128 | Result value |
| illegal | output | 1 | Previous cycle's issued word was not a legal encoding |

## Verification
A wrong register-file entry or a stale forwarding path stays hidden until an instruction reads that register. At that point it shows up in res_data exactly one cycle after the issue. For this reason every test reads the affected registers back through a three-way XOR of a register with itself, which returns its value unchanged. A decode error shows in the same cycle as a wrong illegal/res_valid pair or a wrong res_dest. An error in lane rotation shows only in certain bit positions, so the rotate amounts 0, 1, 42 and 63 are exercised explicitly.

// File: rtl/kx_pkg.sv
package kx_pkg;

  localparam int unsigned REG_AW = 5;

  // bits 31:21 of each legal encoding
  localparam logic [10:0] TOP_EOR3 = 11'h670;
  localparam logic [10:0] TOP_BCAX = 11'h671;
  localparam logic [10:0] TOP_RAX1 = 11'h673;
  localparam logic [10:0] TOP_XAR  = 11'h674;
  localparam logic [5:0]  RAX1_LOW = 6'b100011;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_EOR3 = 3'd1,
    OP_BCAX = 3'd2,
    OP_RAX1 = 3'd3,
    OP_XAR  = 3'd4
  } kx_op_e;

  typedef struct packed {
    kx_op_e            op;
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] src_n;
    logic [REG_AW-1:0] src_m;
    logic [REG_AW-1:0] src_a;
    logic [5:0]        rot;
  } kx_uop_t;

endpackage

// File: rtl/kx_decode.sv
module kx_decode
  import kx_pkg::*;
(
  input  logic [31:0] word,
  output kx_uop_t     uop,
  output logic        legal
);

  logic [10:0] top_bits;
  logic [5:0]  mid_bits;

  always_comb begin
    top_bits  = word[31:21];
    mid_bits  = word[15:10];
    uop.dst   = word[4:0];
    uop.src_n = word[9:5];
    uop.src_m = word[20:16];
    uop.src_a = word[14:10];
    uop.rot   = mid_bits;
    uop.op    = OP_NONE;
    if ((top_bits == TOP_EOR3) && !mid_bits[5]) begin
      uop.op = OP_EOR3;
    end else if ((top_bits == TOP_BCAX) && !mid_bits[5]) begin
      uop.op = OP_BCAX;
    end else if ((top_bits == TOP_RAX1) && (mid_bits == RAX1_LOW)) begin
      uop.op = OP_RAX1;
    end else if (top_bits == TOP_XAR) begin
      uop.op = OP_XAR;
    end
    legal = (uop.op != OP_NONE);
  end

endmodule

// File: rtl/kx_regfile.sv
module kx_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned VW   = 128,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_n_addr,
  input  logic [AW-1:0] rd_m_addr,
  input  logic [AW-1:0] rd_a_addr,
  output logic [VW-1:0] rd_n_data,
  output logic [VW-1:0] rd_m_data,
  output logic [VW-1:0] rd_a_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [VW-1:0] wb_data,
  input  logic          pre_en,
  input  logic [AW-1:0] pre_addr,
  input  logic [VW-1:0] pre_data
);

  logic [VW-1:0] entry_q [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
    logic          wb_hit;
    logic          pre_hit;
    logic          ld_en;
    logic [VW-1:0] entry_d;

    always_comb begin
      wb_hit  = wb_en  && (wb_addr  == AW'(gi));
      pre_hit = pre_en && (pre_addr == AW'(gi));
      ld_en   = wb_hit || pre_hit;
      entry_d = wb_hit ? wb_data : pre_data;
    end

    always_ff @(posedge clk) begin
      if (ld_en) begin
        entry_q[gi] <= entry_d;
      end
    end
  end

  assign rd_n_data = entry_q[rd_n_addr];
  assign rd_m_data = entry_q[rd_m_addr];
  assign rd_a_data = entry_q[rd_a_addr];

endmodule

// File: rtl/kx_lane_alu.sv
module kx_lane_alu
  import kx_pkg::*;
#(
  parameter int unsigned VW   = 128,
  parameter int unsigned LANE = 64,
  localparam int unsigned NLANE = VW / LANE,
  localparam int unsigned RW    = $clog2(LANE)
) (
  input  kx_op_e        op,
  input  logic [RW-1:0] rot,
  input  logic [VW-1:0] opn,
  input  logic [VW-1:0] opm,
  input  logic [VW-1:0] opa,
  output logic [VW-1:0] res
);

  logic [VW-1:0] three_xor;
  logic [VW-1:0] clr_xor;
  logic [VW-1:0] rol_xor;
  logic [VW-1:0] xor_ror;

  assign three_xor = opn ^ opm ^ opa;
  assign clr_xor   = opn ^ (opm & ~opa);

  for (genvar gl = 0; gl < NLANE; gl++) begin : g_lane
    logic [LANE-1:0]   ln_n;
    logic [LANE-1:0]   ln_m;
    logic [LANE-1:0]   ln_x;
    logic [2*LANE-1:0] ln_dbl;

    always_comb begin
      ln_n   = opn[gl*LANE +: LANE];
      ln_m   = opm[gl*LANE +: LANE];
      ln_x   = ln_n ^ ln_m;
      ln_dbl = {ln_x, ln_x} >> rot;
      rol_xor[gl*LANE +: LANE] = ln_n ^ {ln_m[LANE-2:0], ln_m[LANE-1]};
      xor_ror[gl*LANE +: LANE] = ln_dbl[LANE-1:0];
    end
  end

  always_comb begin
    unique case (op)
      OP_EOR3: res = three_xor;
      OP_BCAX: res = clr_xor;
      OP_RAX1: res = rol_xor;
      OP_XAR:  res = xor_ror;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/keccak_vec_xu.sv
module keccak_vec_xu
  import kx_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned VW   = 128,
  parameter int unsigned LANE = 64,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic [31:0]   instr,
  input  logic          pre_en,
  input  logic [AW-1:0] pre_addr,
  input  logic [VW-1:0] pre_data,
  output logic          res_valid,
  output logic [AW-1:0] res_dest,
  output logic [VW-1:0] res_data,
  output logic          illegal
);

  kx_uop_t       uop;
  logic          legal;
  logic [VW-1:0] rf_n, rf_m, rf_a;
  logic [VW-1:0] opn, opm, opa;
  logic [VW-1:0] alu_res;

  logic          res_valid_d, res_valid_q;
  logic          illegal_d, illegal_q;
  logic          res_ld_en;
  logic [AW-1:0] res_dest_d, res_dest_q;
  logic [VW-1:0] res_data_d, res_data_q;

  kx_decode u_dec (
    .word  (instr),
    .uop   (uop),
    .legal (legal)
  );

  kx_regfile #(.NREG(NREG), .VW(VW)) u_rf (
    .clk       (clk),
    .rd_n_addr (uop.src_n),
    .rd_m_addr (uop.src_m),
    .rd_a_addr (uop.src_a),
    .rd_n_data (rf_n),
    .rd_m_data (rf_m),
    .rd_a_data (rf_a),
    .wb_en     (res_valid_q),
    .wb_addr   (res_dest_q),
    .wb_data   (res_data_q),
    .pre_en    (pre_en),
    .pre_addr  (pre_addr),
    .pre_data  (pre_data)
  );

  // forward the pending writeback to a dependent read
  always_comb begin
    opn = (res_valid_q && (res_dest_q == uop.src_n)) ? res_data_q : rf_n;
    opm = (res_valid_q && (res_dest_q == uop.src_m)) ? res_data_q : rf_m;
    opa = (res_valid_q && (res_dest_q == uop.src_a)) ? res_data_q : rf_a;
  end

  kx_lane_alu #(.VW(VW), .LANE(LANE)) u_alu (
    .op  (uop.op),
    .rot (uop.rot),
    .opn (opn),
    .opm (opm),
    .opa (opa),
    .res (alu_res)
  );

  always_comb begin
    res_valid_d = issue_valid && legal;
    illegal_d   = issue_valid && !legal;
    res_ld_en   = res_valid_d;
    res_dest_d  = uop.dst;
    res_data_d  = alu_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      illegal_q   <= 1'b0;
    end else begin
      res_valid_q <= res_valid_d;
      illegal_q   <= illegal_d;
    end
  end

  always_ff @(posedge clk) begin
    if (res_ld_en) begin
      res_dest_q <= res_dest_d;
      res_data_q <= res_data_d;
    end
  end

  assign res_valid = res_valid_q;
  assign res_dest  = res_dest_q;
  assign res_data  = res_data_q;
  assign illegal   = illegal_q;

endmodule

// File: rtl/kx_checker.sv
module kx_checker #(
  parameter int unsigned AW = 5,
  parameter int unsigned VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_valid,
  input logic [31:0]   instr,
  input logic          res_valid,
  input logic [AW-1:0] res_dest,
  input logic [VW-1:0] res_data,
  input logic          illegal
);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && illegal));

  p_issue_resolves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (res_valid ^ illegal));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> (!res_valid && !illegal));

  p_dest_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (!res_valid || (res_dest == $past(instr[4:0]))));

  p_xar_self_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (instr[31:21] == 11'h674) && (instr[9:5] == instr[20:16]))
      |=> (res_valid && (res_data == '0)));

endmodule

bind keccak_vec_xu kx_checker #(.AW(AW), .VW(VW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .instr       (instr),
  .res_valid   (res_valid),
  .res_dest    (res_dest),
  .res_data    (res_data),
  .illegal     (illegal)
);

// File: tb/keccak_vec_xu_tb_top.sv
`timescale 1ns/1ps
module keccak_vec_xu_tb_top;

  logic         clk;
  logic         rst_n;
  logic         issue_valid;
  logic [31:0]  instr;
  logic         pre_en;
  logic [4:0]   pre_addr;
  logic [127:0] pre_data;
  logic         res_valid;
  logic [4:0]   res_dest;
  logic [127:0] res_data;
  logic         illegal;

  int checks;
  int failures;
  bit done;
  logic [127:0] mdl [32];

  keccak_vec_xu dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .instr       (instr),
    .pre_en      (pre_en),
    .pre_addr    (pre_addr),
    .pre_data    (pre_data),
    .res_valid   (res_valid),
    .res_dest    (res_dest),
    .res_data    (res_data),
    .illegal     (illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- encoders ----------------
  function automatic logic [31:0] w_eor3(int d, int n, int m, int a);
    return 32'hCE000000 | (32'(m) << 16) | (32'(a) << 10) | (32'(n) << 5) | 32'(d);
  endfunction
  function automatic logic [31:0] w_bcax(int d, int n, int m, int a);
    return 32'hCE200000 | (32'(m) << 16) | (32'(a) << 10) | (32'(n) << 5) | 32'(d);
  endfunction
  function automatic logic [31:0] w_rax1(int d, int n, int m);
    return 32'hCE608C00 | (32'(m) << 16) | (32'(n) << 5) | 32'(d);
  endfunction
  function automatic logic [31:0] w_xar(int d, int n, int m, int r);
    return 32'hCE800000 | (32'(m) << 16) | (32'(r) << 10) | (32'(n) << 5) | 32'(d);
  endfunction

  // ---------------- reference ----------------
  function automatic logic [63:0] ref_ror(logic [63:0] x, int r);
    logic [63:0] o;
    for (int i = 0; i < 64; i++) o[i] = x[(i + r) % 64];
    return o;
  endfunction
  function automatic logic [127:0] ref_rax1(logic [127:0] n, logic [127:0] m);
    logic [127:0] o;
    for (int l = 0; l < 2; l++)
      o[l*64 +: 64] = n[l*64 +: 64] ^ ref_ror(m[l*64 +: 64], 63);
    return o;
  endfunction
  function automatic logic [127:0] ref_xar(logic [127:0] n, logic [127:0] m, int r);
    logic [127:0] o;
    for (int l = 0; l < 2; l++)
      o[l*64 +: 64] = ref_ror(n[l*64 +: 64] ^ m[l*64 +: 64], r);
    return o;
  endfunction
  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic preload(int r, logic [127:0] v);
    @(negedge clk);
    pre_en = 1'b1; pre_addr = 5'(r); pre_data = v;
    @(negedge clk);
    pre_en = 1'b0;
    mdl[r] = v;
  endtask

  // issue one word; returns at the negedge after the capturing edge
  task automatic issue(logic [31:0] w);
    issue_valid = 1'b1; instr = w;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic expect_result(string tag, int d, logic [127:0] exp);
    chk({tag, " valid"}, 128'(res_valid), 128'd1);
    chk({tag, " dest R5"}, 128'(res_dest), 128'(d));
    chk(tag, res_data, exp);
    mdl[d] = exp;
  endtask

  task automatic readback(string tag, int r);
    issue(w_eor3(r, r, r, r));
    expect_result(tag, r, mdl[r]);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; issue_valid = 1'b0; instr = '0; pre_en = 1'b0;
    pre_addr = '0; pre_data = '0;
    repeat (3) @(negedge clk);
    chk("R9 valid in reset", 128'(res_valid), 128'd0);
    chk("R9 illegal in reset", 128'(illegal), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 valid after release", 128'(res_valid), 128'd0);
    chk("R9 illegal after release", 128'(illegal), 128'd0);
  endtask

  task automatic t_fill();
    for (int r = 0; r < 32; r++) preload(r, rnd128());
  endtask

  task automatic t_eor3();
    for (int k = 0; k < 8; k++) begin
      int d = $urandom_range(31), n = $urandom_range(31);
      int m = $urandom_range(31), a = $urandom_range(31);
      logic [127:0] e = mdl[n] ^ mdl[m] ^ mdl[a];
      issue(w_eor3(d, n, m, a));
      expect_result("R1 eor3", d, e);
    end
  endtask

  task automatic t_bcax();
    for (int k = 0; k < 8; k++) begin
      int d = $urandom_range(31), n = $urandom_range(31);
      int m = $urandom_range(31), a = $urandom_range(31);
      logic [127:0] e = mdl[n] ^ (mdl[m] & ~mdl[a]);
      issue(w_bcax(d, n, m, a));
      expect_result("R2 bcax", d, e);
    end
  endtask

  task automatic t_rax1();
    preload(3, {64'h8000_0000_0000_0001, 64'hC000_0000_0000_0000});
    preload(4, '0);
    issue(w_rax1(5, 4, 3));
    expect_result("R3 rax1 lane wrap", 5,
                  {64'h0000_0000_0000_0003, 64'h8000_0000_0000_0001});
    for (int k = 0; k < 6; k++) begin
      int d = $urandom_range(31), n = $urandom_range(31), m = $urandom_range(31);
      logic [127:0] e = ref_rax1(mdl[n], mdl[m]);
      issue(w_rax1(d, n, m));
      expect_result("R3 rax1", d, e);
    end
  endtask

  task automatic t_xar();
    int rots[6] = '{0, 1, 63, 42, 17, 32};
    foreach (rots[i]) begin
      int d = $urandom_range(31), n = $urandom_range(31), m = $urandom_range(31);
      logic [127:0] e;
      if (n == m) m = (m + 1) % 32;
      e = ref_xar(mdl[n], mdl[m], rots[i]);
      if (rots[i] == 0) chk("R4 rot0 passthrough ref", e, mdl[n] ^ mdl[m]);
      issue(w_xar(d, n, m, rots[i]));
      expect_result("R4 xar", d, e);
    end
    issue(w_xar(9, 12, 12, 42));
    expect_result("R4 xar n==m zero", 9, '0);
  endtask

  task automatic t_illegal();
    logic [31:0] bad[5] = '{32'hCE008000, 32'hCE208000, 32'hCE600000,
                            32'hCEA00000, 32'h00000000};
    foreach (bad[i]) begin
      int t = 20 + i;
      issue(bad[i] | 32'(t) | (32'(t) << 5));
      chk("R6 illegal flag", 128'(illegal), 128'd1);
      chk("R6 no result", 128'(res_valid), 128'd0);
      @(negedge clk);
      chk("R6 flag one cycle", 128'(illegal), 128'd0);
      readback("R6 no write", t);
    end
  endtask

  task automatic t_idle();
    logic [127:0] old = mdl[14];
    issue_valid = 1'b0; instr = w_eor3(14, 1, 2, 3);
    @(negedge clk);
    chk("R7 idle no valid", 128'(res_valid), 128'd0);
    chk("R7 idle no illegal", 128'(illegal), 128'd0);
    readback("R7 idle no write", 14);
    chk("R7 idle value kept", mdl[14], old);
  endtask

  task automatic t_b2b();
    logic [127:0] e1, e2;
    e1 = mdl[1] ^ mdl[2] ^ mdl[6];
    issue_valid = 1'b1; instr = w_eor3(10, 1, 2, 6);
    @(negedge clk);
    e2 = ref_rax1(e1, e1);
    instr = w_rax1(11, 10, 10);
    expect_result("R8 producer", 10, e1);
    @(negedge clk);
    issue_valid = 1'b0;
    expect_result("R8 dependent", 11, e2);
    e1 = mdl[11] ^ (mdl[11] & ~mdl[0]);
    issue_valid = 1'b1; instr = w_bcax(11, 11, 11, 0);
    @(negedge clk);
    e2 = ref_xar(mdl[4] ^ 0, e1, 1);
    instr = w_xar(12, 4, 11, 1);
    expect_result("R8 self-dest", 11, e1);
    @(negedge clk);
    issue_valid = 1'b0;
    expect_result("R8 dependent on m", 12, e2);
  endtask

  task automatic t_preload_fresh();
    logic [127:0] v = rnd128();
    preload(7, v);
    issue(w_eor3(8, 7, 7, 7));
    expect_result("R10 preload visible next cycle", 8, v);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    t_reset();
    t_fill();
    t_eor3();
    t_bcax();
    t_rax1();
    t_xar();
    t_illegal();
    t_idle();
    t_b2b();
    t_preload_fresh();
    repeat (2) @(negedge clk);
    report();
  end

endmodule